// File: doc/BRIEF.md
# Ultrasonic Ranging Presence Detector

This block times an ultrasonic range sensor. At the start of every fixed measurement cycle it raises a start line for a short burst, then counts fixed-length time ticks until the returned echo is seen. The count, in tick units, is the round-trip distance measure. With a 0.1 ms tick one count is about 0.055 ft. Each measurement ends with a one-clock valid strobe and a distance value on the output. A presence flag tells whether the target sits inside a configured near/far window.

If no echo edge arrives before the count would pass its ceiling, the ping is abandoned. The counter is cleared, and the measurement is reported as "no target" with presence cleared. The echo input is asynchronous and passes through a two-flop synchronizer. Only its rising edge, while the block is waiting for a return, ends a measurement.

The prescaler, cycle length, start-pulse width, count ceiling and window bounds are all parameters in counts. A downstream controller uses the valid strobe and presence flag to decide whether to begin a badge exchange.

Top module: `sonar_presence`

## Requirements
- R1: While reset is held and right after it, `init_o` and `valid_o` are 0, `dist_o` is 0 and `present_o` is 0.
- R2: `init_o` is 1 for exactly INIT_TICKS*TICK_DIV clocks at the start of each measurement cycle and 0 at every other time.
- R3: Suppose ECHO is raised right after the clock edge plus m further edges, where the edge is the one at which `init_o` fell. Then the reported distance is floor((m+2)/TICK_DIV). This holds while that value does not exceed MAX_COUNT. The internal count grows by exactly one per tick while waiting.
- R4: Every measurement gives `valid_o` high for exactly one clock. `dist_o` keeps its value until the next strobe.
- R5: Suppose no echo edge has been taken when a tick arrives with the count already at MAX_COUNT. Then the ping is abandoned and `valid_o` strobes with `dist_o` all ones (the no-target code).
- R6: On a strobe with a real distance d, `present_o` becomes 1 when NEAR_CNT <= d <= FAR_CNT and 0 otherwise. On a no-target strobe it becomes 0. Between strobes it does not change.
- R7: Pings start every CYCLE_TICKS*TICK_DIV clocks. The first `init_o` rise comes on the CYCLE_TICKS*TICK_DIV-th clock edge after reset is released.
- R8: An echo edge taken in the same clock as the tick that would abandon the ping wins. MAX_COUNT is reported.
- R9: Echo edges outside the waiting phase are ignored: no strobe follows them. An echo already high when waiting begins yields the no-target result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| echo_i | input | 1 | Asynchronous echo return from the sensor |
| init_o | output | 1 | Ping start line to the sensor |
| dist_o | output | DIST_W | Last measured distance in ticks, all ones for no target |
| valid_o | output | 1 | One-clock strobe marking a finished measurement |
| present_o | output | 1 | Target inside the near/far window at the last measurement |

## Verification
The echo capture and the count-ceiling abort can both fall on the same clock: the synchronized echo edge arrives exactly on the tick that would carry the count past MAX_COUNT. The bench provokes this by raising ECHO MAX_COUNT*TICK_DIV edges after `init_o` falls. With the two synchronizer flops, the edge then lands on that tick. It repeats the stimulus one clock later to get the abort. Both outcomes are judged against a clock-by-clock reference model: the first must report MAX_COUNT with a valid strobe, the second the no-target code with presence cleared.

// File: rtl/sonar_pkg.sv
package sonar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INIT  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_ABORT = 2'd3
  } sonar_state_e;

  // Inclusive presence window test on a distance in ticks.
  function automatic logic in_window(input int unsigned d,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (d >= lo) && (d <= hi);
  endfunction

  // Counter step with wrap at a terminal value.
  function automatic int unsigned wrap_inc(input int unsigned v,
                                           input int unsigned last);
    return (v == last) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/sonar_tick_gen.sv
module sonar_tick_gen #(
  parameter int unsigned TICK_DIV    = 20000,
  parameter int unsigned CYCLE_TICKS = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic cycle_start_o
);
  localparam int unsigned PW  = $clog2(TICK_DIV + 1);
  localparam int unsigned CTW = $clog2(CYCLE_TICKS + 1);

  logic [PW-1:0]  presc_q;
  logic [CTW-1:0] cyc_q;

  assign tick_o        = (presc_q == PW'(TICK_DIV - 1));
  assign cycle_start_o = tick_o && (cyc_q == CTW'(CYCLE_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      cyc_q   <= '0;
    end else begin
      presc_q <= PW'(sonar_pkg::wrap_inc(32'(presc_q), TICK_DIV - 1));
      if (tick_o)
        cyc_q <= CTW'(sonar_pkg::wrap_inc(32'(cyc_q), CYCLE_TICKS - 1));
    end
  end
endmodule

// File: rtl/sonar_echo_sync.sv
module sonar_echo_sync (
  input  logic clk,
  input  logic rst,
  input  logic echo_i,
  output logic rise_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= echo_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q && !last_q;
endmodule

// File: rtl/sonar_range_fsm.sv
module sonar_range_fsm #(
  parameter int unsigned INIT_TICKS = 1,
  parameter int unsigned MAX_COUNT  = 60,
  localparam int unsigned CW = $clog2(MAX_COUNT + 1),
  localparam int unsigned IW = $clog2(INIT_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          cycle_start_i,
  input  logic          rise_i,
  output logic          init_o,
  output logic          wait_o,
  output logic [CW-1:0] count_o,
  output logic          hit_o,
  output logic          miss_o
);
  import sonar_pkg::*;

  sonar_state_e  state_q;
  logic [IW-1:0] icnt_q;
  logic [CW-1:0] cnt_q;
  logic          at_max;

  assign at_max  = (cnt_q == CW'(MAX_COUNT));
  assign init_o  = (state_q == ST_INIT);
  assign wait_o  = (state_q == ST_WAIT);
  assign count_o = cnt_q;
  assign hit_o   = wait_o && rise_i;
  assign miss_o  = wait_o && !rise_i && tick_i && at_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      icnt_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cycle_start_i) begin
            state_q <= ST_INIT;
            icnt_q  <= '0;
          end
        end
        ST_INIT: begin
          if (tick_i) begin
            if (icnt_q == IW'(INIT_TICKS - 1)) begin
              state_q <= ST_WAIT;
              cnt_q   <= '0;
            end else begin
              icnt_q <= icnt_q + IW'(1);
            end
          end
        end
        ST_WAIT: begin
          if (rise_i) begin
            state_q <= ST_IDLE;
          end else if (tick_i) begin
            if (at_max) begin
              state_q <= ST_ABORT;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
        end
        ST_ABORT: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sonar_presence.sv
module sonar_presence #(
  parameter int unsigned TICK_DIV    = 20000,
  parameter int unsigned CYCLE_TICKS = 2000,
  parameter int unsigned INIT_TICKS  = 1,
  parameter int unsigned MAX_COUNT   = 60,
  parameter int unsigned NEAR_CNT    = 9,
  parameter int unsigned FAR_CNT     = 54,
  parameter int unsigned DIST_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              echo_i,
  output logic              init_o,
  output logic [DIST_W-1:0] dist_o,
  output logic              valid_o,
  output logic              present_o
);
  localparam int unsigned CW = $clog2(MAX_COUNT + 1);
  localparam logic [DIST_W-1:0] NO_TARGET = '1;

  // Named internal events, visible to the bound checker.
  logic          tick_w;
  logic          cycle_start_w;
  logic          rise_w;
  logic          wait_w;
  logic          hit_w;
  logic          miss_w;
  logic [CW-1:0] count_w;

  logic [DIST_W-1:0] dist_q;
  logic              valid_q;
  logic              present_q;

  sonar_tick_gen #(
    .TICK_DIV   (TICK_DIV),
    .CYCLE_TICKS(CYCLE_TICKS)
  ) u_tick (
    .clk          (clk),
    .rst          (rst),
    .tick_o       (tick_w),
    .cycle_start_o(cycle_start_w)
  );

  sonar_echo_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .echo_i(echo_i),
    .rise_o(rise_w)
  );

  sonar_range_fsm #(
    .INIT_TICKS(INIT_TICKS),
    .MAX_COUNT (MAX_COUNT)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_w),
    .cycle_start_i(cycle_start_w),
    .rise_i       (rise_w),
    .init_o       (init_o),
    .wait_o       (wait_w),
    .count_o      (count_w),
    .hit_o        (hit_w),
    .miss_o       (miss_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dist_q    <= '0;
      valid_q   <= 1'b0;
      present_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (hit_w) begin
        dist_q    <= DIST_W'(count_w);
        present_q <= sonar_pkg::in_window(32'(count_w), NEAR_CNT, FAR_CNT);
        valid_q   <= 1'b1;
      end else if (miss_w) begin
        dist_q    <= NO_TARGET;
        present_q <= 1'b0;
        valid_q   <= 1'b1;
      end
    end
  end

  assign dist_o    = dist_q;
  assign valid_o   = valid_q;
  assign present_o = present_q;
endmodule

// File: rtl/sonar_presence_chk.sv
module sonar_presence_chk #(
  parameter int unsigned MAX_COUNT = 60,
  parameter int unsigned NEAR_CNT  = 9,
  parameter int unsigned FAR_CNT   = 54,
  parameter int unsigned DIST_W    = 8,
  parameter int unsigned CW        = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              init_o,
  input logic [DIST_W-1:0] dist_o,
  input logic              valid_o,
  input logic              present_o,
  input logic              tick_w,
  input logic              wait_w,
  input logic              hit_w,
  input logic              miss_w,
  input logic [CW-1:0]     count_w
);
  localparam logic [DIST_W-1:0] NO_TARGET = '1;

  a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r2_init_quiet_on_valid: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !init_o);

  a_r5_miss_clears_presence: assert property (@(posedge clk) disable iff (rst)
    (valid_o && dist_o == NO_TARGET) |-> !present_o);

  a_r6_presence_window: assert property (@(posedge clk) disable iff (rst)
    (valid_o && dist_o != NO_TARGET) |->
      (present_o == ((32'(dist_o) >= NEAR_CNT) && (32'(dist_o) <= FAR_CNT))));

  a_r6_presence_holds: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(present_o));

  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    (wait_w && tick_w && !hit_w && !miss_w) |=> (count_w == $past(count_w) + CW'(1)));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    wait_w |-> (32'(count_w) <= MAX_COUNT));

  a_r7_ping_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(init_o) |-> $past(tick_w));

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (rst)
    (hit_w || miss_w) |=> (valid_o && !wait_w));
endmodule

bind sonar_presence sonar_presence_chk #(
  .MAX_COUNT(MAX_COUNT),
  .NEAR_CNT (NEAR_CNT),
  .FAR_CNT  (FAR_CNT),
  .DIST_W   (DIST_W),
  .CW       (CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .init_o   (init_o),
  .dist_o   (dist_o),
  .valid_o  (valid_o),
  .present_o(present_o),
  .tick_w   (tick_w),
  .wait_w   (wait_w),
  .hit_w    (hit_w),
  .miss_w   (miss_w),
  .count_w  (count_w)
);

// File: tb/tb_sonar_presence.sv
`timescale 1ns/1ps
module tb_sonar_presence;
  localparam int TD   = 3;
  localparam int CT   = 60;
  localparam int IT   = 2;
  localparam int MAXC = 40;
  localparam int NEAR = 8;
  localparam int FAR  = 30;
  localparam int DW   = 8;
  localparam int NOT  = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic echo = 1'b0;
  logic init_o, valid_o, present_o;
  logic [DW-1:0] dist_o;

  int checks = 0;
  int fails  = 0;
  int edge_cnt = 0;
  int last_rise = -1;
  bit done = 0;

  always #2.5 clk = ~clk;

  sonar_presence #(
    .TICK_DIV(TD), .CYCLE_TICKS(CT), .INIT_TICKS(IT), .MAX_COUNT(MAXC),
    .NEAR_CNT(NEAR), .FAR_CNT(FAR), .DIST_W(DW)
  ) dut (
    .clk(clk), .rst(rst), .echo_i(echo), .init_o(init_o),
    .dist_o(dist_o), .valid_o(valid_o), .present_o(present_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference: phase by elapsed edges, echo history in a queue.
  int  n = 0;
  int  phase = 0;
  int  icnt = 0;
  int  dcnt = 0;
  bit  m_init = 0, m_valid = 0, m_pres = 0;
  int  m_dist = 0;
  bit  hist[$];

  always @(posedge clk) begin
    if (rst) begin
      n = 0; phase = 0; icnt = 0; dcnt = 0;
      m_init = 0; m_valid = 0; m_pres = 0; m_dist = 0;
      hist.delete();
    end else begin
      bit tk, cs, s2, s3, rise;
      tk = (n % TD) == TD - 1;
      cs = (n % (TD * CT)) == TD * CT - 1;
      s2 = (hist.size() >= 2) ? hist[hist.size()-2] : 1'b0;
      s3 = (hist.size() >= 3) ? hist[hist.size()-3] : 1'b0;
      rise = s2 && !s3;
      m_valid = 0;
      case (phase)
        0: if (cs) begin phase = 1; icnt = 0; end
        1: if (tk) begin
             if (icnt == IT - 1) begin phase = 2; dcnt = 0; end
             else icnt++;
           end
        2: if (rise) begin
             m_valid = 1; m_dist = dcnt;
             m_pres = (dcnt >= NEAR) && (dcnt <= FAR); phase = 0;
           end else if (tk) begin
             if (dcnt == MAXC) begin
               m_valid = 1; m_dist = NOT; m_pres = 0; dcnt = 0; phase = 3;
             end else dcnt++;
           end
        default: phase = 0;
      endcase
      m_init = (phase == 1);
      hist.push_back(echo);
      if (hist.size() > 4) void'(hist.pop_front());
      n++;
      edge_cnt++;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(init_o == m_init, "R2 model init", int'(init_o), int'(m_init));
      check(valid_o == m_valid, "R4 model valid", int'(valid_o), int'(m_valid));
      check(int'(dist_o) == m_dist, "R4 model dist", int'(dist_o), m_dist);
      check(present_o == m_pres, "R6 model presence", int'(present_o), int'(m_pres));
    end
  end

  // mode 0: echo m edges after INIT falls; 1: no echo; 2: echo raised during INIT
  task automatic run_ping(input int m, input int mode, input string tag);
    int w = 0;
    int lim = 0;
    int t0;
    int d_exp;
    bit p_exp;
    while (!init_o) @(negedge clk);
    t0 = edge_cnt;
    if (last_rise < 0)
      check(t0 == TD * CT, "R7 first ping time", t0, TD * CT);
    else
      check(t0 - last_rise == TD * CT, "R7 ping period", t0 - last_rise, TD * CT);
    last_rise = t0;
    if (mode == 2) echo = 1'b1;
    while (init_o) begin w++; @(negedge clk); end
    check(w == IT * TD, "R2 init width", w, IT * TD);
    if (mode == 0) begin
      repeat (m) @(negedge clk);
      echo = 1'b1;
    end
    while (!valid_o && lim < 400) begin @(negedge clk); lim++; end
    if (mode == 0 && m + 3 <= (MAXC + 1) * TD) d_exp = (m + 2) / TD;
    else d_exp = NOT;
    p_exp = (d_exp != NOT) && (d_exp >= NEAR) && (d_exp <= FAR);
    check(valid_o == 1'b1, {tag, " strobe"}, int'(valid_o), 1);
    check(int'(dist_o) == d_exp, {tag, " distance"}, int'(dist_o), d_exp);
    check(present_o == p_exp, {tag, " presence"}, int'(present_o), int'(p_exp));
    @(negedge clk);
    check(valid_o == 1'b0, "R4 strobe one clock", int'(valid_o), 0);
    echo = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(init_o == 0 && valid_o == 0 && dist_o == 0 && present_o == 0,
          "R1 reset outputs", int'({init_o, valid_o, present_o}) + int'(dist_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(init_o == 0 && valid_o == 0 && dist_o == 0 && present_o == 0,
          "R1 after release", int'({init_o, valid_o, present_o}) + int'(dist_o), 0);

    run_ping(10 * TD, 0, "R3 mid range");
    repeat (50) @(negedge clk);
    check(present_o == 1'b1, "R6 presence held", int'(present_o), 1);
    run_ping(0, 0, "R3 zero count");
    run_ping((NEAR - 1) * TD, 0, "R6 just near");
    run_ping(NEAR * TD, 0, "R6 near bound");
    run_ping(FAR * TD, 0, "R6 far bound");
    run_ping((FAR + 1) * TD, 0, "R6 just far");
    run_ping(FAR * TD + 1, 0, "R3 offset echo");
    run_ping(MAXC * TD, 0, "R8 echo on abort tick");
    run_ping(MAXC * TD + 1, 0, "R5 echo one late");
    run_ping(0, 1, "R5 no echo");

    // R9: an echo pulse during idle produces no strobe
    repeat (10) @(negedge clk);
    echo = 1'b1;
    repeat (3) @(negedge clk);
    echo = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (valid_o) seen++;
      end
      check(seen == 0, "R9 idle echo ignored", seen, 0);
    end
    run_ping(0, 2, "R9 echo during init");
    run_ping(12 * TD, 0, "R3 recovery");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    finish_run();
  end
endmodule